// File: doc/BRIEF.md
# Three-Stage Decimating Filter Chain

This block is the filtering back end of a digital downconverter path. It takes one real sample stream, either the I or the Q output of a quadrature mixer, at the full converter rate. It lowers that rate by a factor of 256 in three fixed steps. The first step is a multiplier-free cascaded integrator-comb (CIC) decimator that divides the rate by 64. The second is a 21-tap FIR that divides by 2 and lifts the passband to undo the CIC droop. The third is a 63-tap FIR that divides by 2 again and sets the final channel shape. With an input near 69.333 MHz the output lands near 270 kHz, which leaves room for an 80 kHz wide channel.

Samples enter on a valid-qualified bus, at most one per clock. They leave on a valid-qualified bus at the final rate. A quadrature receiver uses two instances, one per path. Each FIR works out only the outputs it keeps. It uses one multiply-accumulate unit that steps through its taps in the idle cycles between its input samples. Every stage rounds its result to nearest, with halves rounded up, and saturates it before passing it on.

Top module: `ddc_decim_chain`

## Requirements
- R1: The CIC stage has 5 integrator/comb sections, a differential delay of 1 and a ratio of 64. It produces one result on the 64th, 128th, ... accepted input. That result is the input convolved with the 5-fold convolution of a 64-sample all-ones window, divided by 2^30, rounded half up and saturated to 16 bits.
- R2: The compensation stage produces one output for every second CIC result. The output is sum over k of c1[k]*x[n-k] for k = 0..20, where x[n] is the newest result and c1 is signed Q1.15. The sum is divided by 2^15, rounded half up and saturated to 16 bits. Results from before the last reset count as zero.
- R3: The shaping stage follows the same rule with 63 taps c2[0..62], fed by the compensation outputs, and drives out_data.
- R4: Exactly one out_valid pulse, one cycle wide, appears for every 256 accepted inputs. The first one after reset belongs to the 256th accepted input.
- R5: Cycles with in_valid low have no effect, whatever in_data holds.
- R6: Every stage clamps its result to the range -32768..32767 instead of wrapping.
- R7: A synchronous reset (rst high at a clock edge) clears all integrators, comb delays, FIR histories and phase counters. During and after reset, out_valid is 0 and out_data is 0 until the first new output.
- R8: out_data changes only in the cycle in which out_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_data for one cycle |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | One-cycle pulse at the decimated rate |
| out_data | output | OUT_W | Signed output sample, held between pulses |

## Verification
The hardest case to reach from the ports is a reset in the middle of a stream. The FIR histories sit in RAM that the reset does not clear, so stale samples are still in memory and must be masked out by the fill counter. The stimulus fills the chain with a large constant, resets it part way through a frame, then feeds a different constant for exactly one frame. The single output that follows is compared with a model whose history starts from zero. Long runs of full-scale positive and negative input drive the compensation stage, whose DC gain is above one, into saturation. A run with sparse valid strobes and garbage data on the idle cycles checks that gaps change nothing.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int SAMPLE_W_DEF   = 16;
  localparam int COEF_W_DEF     = 16;
  localparam int COMP_TAPS_DEF  = 21;
  localparam int SHAPE_TAPS_DEF = 63;

  // Default compensation taps: symmetric, centre peak with negative side lobes.
  function automatic logic [COMP_TAPS_DEF*COEF_W_DEF-1:0] comp_coefs_default();
    logic [COMP_TAPS_DEF*COEF_W_DEF-1:0] v;
    int d;
    int c;
    v = '0;
    for (int k = 0; k < COMP_TAPS_DEF; k++) begin
      d = (k > COMP_TAPS_DEF/2) ? k - COMP_TAPS_DEF/2 : COMP_TAPS_DEF/2 - k;
      case (d)
        0: c = 20000;
        1: c = 8000;
        2: c = -1500;
        3: c = 600;
        default: c = 0;
      endcase
      v[k*COEF_W_DEF +: COEF_W_DEF] = COEF_W_DEF'(c);
    end
    return v;
  endfunction

  // Default shaping taps: triangular window with unity DC gain.
  function automatic logic [SHAPE_TAPS_DEF*COEF_W_DEF-1:0] shape_coefs_default();
    logic [SHAPE_TAPS_DEF*COEF_W_DEF-1:0] v;
    int d;
    v = '0;
    for (int k = 0; k < SHAPE_TAPS_DEF; k++) begin
      d = (k > SHAPE_TAPS_DEF/2) ? k - SHAPE_TAPS_DEF/2 : SHAPE_TAPS_DEF/2 - k;
      v[k*COEF_W_DEF +: COEF_W_DEF] = COEF_W_DEF'((SHAPE_TAPS_DEF/2 + 1 - d) * 32);
    end
    return v;
  endfunction
endpackage

// File: rtl/ddc_cic_decim.sv
module ddc_cic_decim #(
  parameter int IW     = 16,
  parameter int OW     = 16,
  parameter int STAGES = 5,
  parameter int RATIO  = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int RLOG  = $clog2(RATIO);
  localparam int SHIFT = STAGES * RLOG;
  localparam int W     = IW + SHIFT;
  localparam logic signed [W:0] HALF = (W+1)'(longint'(1) <<< (SHIFT-1));
  localparam logic signed [W:0] OMAX = (W+1)'((longint'(1) <<< (OW-1)) - 1);
  localparam logic signed [W:0] OMIN = -OMAX - 1;

  logic signed [W-1:0] integ [STAGES];
  logic signed [W-1:0] isum  [STAGES];
  logic signed [W-1:0] dly   [STAGES];
  logic signed [W-1:0] cdiff [STAGES];
  logic [RLOG-1:0]     phase;
  logic                dec;
  logic signed [W:0]   rnd;
  logic signed [OW-1:0] sat;

  // Integrator chain: all sections settle in the cycle of the sample.
  assign isum[0] = integ[0] + W'(in_data);
  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_int
      assign isum[i] = integ[i] + isum[i-1];
    end
  endgenerate

  // Comb chain at the decimated rate.
  assign cdiff[0] = isum[STAGES-1] - dly[0];
  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_comb
      assign cdiff[i] = cdiff[i-1] - dly[i];
    end
  endgenerate

  assign dec = in_valid && (phase == RLOG'(RATIO-1));
  assign rnd = ((W+1)'(cdiff[STAGES-1]) + HALF) >>> SHIFT;

  always_comb begin
    if (rnd > OMAX)      sat = OMAX[OW-1:0];
    else if (rnd < OMIN) sat = OMIN[OW-1:0];
    else                 sat = rnd[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) begin
        integ[i] <= '0;
        dly[i]   <= '0;
      end
      phase     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        for (int i = 0; i < STAGES; i++) integ[i] <= isum[i];
        phase <= dec ? '0 : phase + 1'b1;
      end
      if (dec) begin
        dly[0] <= isum[STAGES-1];
        for (int i = 1; i < STAGES; i++) dly[i] <= cdiff[i-1];
        out_valid <= 1'b1;
        out_data  <= sat;
      end
    end
  end

  assert_dec_follows_input_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(integ[0]));
endmodule

// File: rtl/ddc_fir_decim.sv
module ddc_fir_decim #(
  parameter int DW   = 16,
  parameter int OW   = 16,
  parameter int CW   = 16,
  parameter int TAPS = 21,
  parameter int FRAC = 15,
  parameter logic [TAPS*CW-1:0] COEFS = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int AW  = $clog2(TAPS);
  localparam int KW  = $clog2(TAPS+1);
  localparam int PW  = DW + CW;
  localparam int ACW = PW + $clog2(TAPS) + 1;
  localparam logic signed [ACW:0] HALF = (ACW+1)'(longint'(1) <<< (FRAC-1));
  localparam logic signed [ACW:0] OMAX = (ACW+1)'((longint'(1) <<< (OW-1)) - 1);
  localparam logic signed [ACW:0] OMIN = -OMAX - 1;

  // History RAM: no reset, so it maps onto block memory.
  logic signed [DW-1:0] mem [TAPS];
  logic [AW-1:0]        wp, wp_next, base, rd_addr;
  logic [KW-1:0]        fill, k;
  logic                 phase, busy;
  logic                 mac_v, mac_first, mac_last, tap_ok, fin;
  logic signed [DW-1:0] rd_q;
  logic signed [CW-1:0] coef_q;
  logic signed [PW-1:0] prod;
  logic signed [ACW-1:0] acc;
  logic signed [ACW:0]  rnd;
  logic signed [OW-1:0] sat;
  int                   rd_diff;

  assign wp_next = (wp == AW'(TAPS-1)) ? '0 : wp + 1'b1;

  always_comb begin
    rd_diff = int'(base) - int'(k);
    if (rd_diff < 0) rd_diff = rd_diff + TAPS;
    rd_addr = AW'(rd_diff);
  end

  always_ff @(posedge clk) begin
    if (in_valid) mem[wp] <= in_data;
    rd_q <= mem[rd_addr];
  end

  assign prod = PW'(rd_q) * PW'(coef_q);
  assign rnd  = ((ACW+1)'(acc) + HALF) >>> FRAC;

  always_comb begin
    if (rnd > OMAX)      sat = OMAX[OW-1:0];
    else if (rnd < OMIN) sat = OMIN[OW-1:0];
    else                 sat = rnd[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; base <= '0; fill <= '0; k <= '0;
      phase <= 1'b0; busy <= 1'b0;
      mac_v <= 1'b0; mac_first <= 1'b0; mac_last <= 1'b0; tap_ok <= 1'b0; fin <= 1'b0;
      coef_q <= '0; acc <= '0;
      out_valid <= 1'b0; out_data <= '0;
    end else begin
      out_valid <= 1'b0;
      // Issue stage: one tap address per cycle.
      mac_v     <= busy;
      mac_first <= busy && (k == '0);
      mac_last  <= busy && (k == KW'(TAPS-1));
      tap_ok    <= k < fill;
      coef_q    <= COEFS[int'(k)*CW +: CW];
      if (busy) begin
        if (k == KW'(TAPS-1)) begin
          busy <= 1'b0;
          k    <= '0;
        end else begin
          k <= k + 1'b1;
        end
      end
      if (in_valid) begin
        wp    <= wp_next;
        phase <= ~phase;
        if (fill != KW'(TAPS)) fill <= fill + 1'b1;
        if (phase) begin
          busy <= 1'b1;
          k    <= '0;
          base <= wp;
        end
      end
      // Accumulate stage.
      if (mac_v)
        acc <= (mac_first ? '0 : acc) + (tap_ok ? ACW'(prod) : '0);
      fin <= mac_v && mac_last;
      if (fin) begin
        out_valid <= 1'b1;
        out_data  <= sat;
      end
    end
  end

  assert_mac_done_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> !busy);
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));
endmodule

// File: rtl/ddc_decim_chain.sv
module ddc_decim_chain #(
  parameter int IN_W        = ddc_pkg::SAMPLE_W_DEF,
  parameter int MID_W       = ddc_pkg::SAMPLE_W_DEF,
  parameter int OUT_W       = ddc_pkg::SAMPLE_W_DEF,
  parameter int COEF_W      = ddc_pkg::COEF_W_DEF,
  parameter int COEF_FRAC   = 15,
  parameter int CIC_STAGES  = 5,
  parameter int CIC_RATIO   = 64,
  parameter int COMP_TAPS   = ddc_pkg::COMP_TAPS_DEF,
  parameter int SHAPE_TAPS  = ddc_pkg::SHAPE_TAPS_DEF,
  parameter logic [COMP_TAPS*COEF_W-1:0]  COMP_COEFS  = ddc_pkg::comp_coefs_default(),
  parameter logic [SHAPE_TAPS*COEF_W-1:0] SHAPE_COEFS = ddc_pkg::shape_coefs_default()
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  logic                   cic_v, comp_v;
  logic signed [IN_W-1:0]  cic_d;
  logic signed [MID_W-1:0] comp_d;

  ddc_cic_decim #(.IW(IN_W), .OW(IN_W), .STAGES(CIC_STAGES), .RATIO(CIC_RATIO)) u_cic (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(cic_v), .out_data(cic_d));

  ddc_fir_decim #(.DW(IN_W), .OW(MID_W), .CW(COEF_W), .TAPS(COMP_TAPS),
                  .FRAC(COEF_FRAC), .COEFS(COMP_COEFS)) u_comp (
    .clk(clk), .rst(rst), .in_valid(cic_v), .in_data(cic_d),
    .out_valid(comp_v), .out_data(comp_d));

  ddc_fir_decim #(.DW(MID_W), .OW(OUT_W), .CW(COEF_W), .TAPS(SHAPE_TAPS),
                  .FRAC(COEF_FRAC), .COEFS(SHAPE_COEFS)) u_shape (
    .clk(clk), .rst(rst), .in_valid(comp_v), .in_data(comp_d),
    .out_valid(out_valid), .out_data(out_data));

  assert_reset_quiet_R7: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));
endmodule

// File: tb/tb_ddc_decim_chain.sv
module tb_ddc_decim_chain;
  function automatic int c1(int k);
    int d;
    d = (k > 10) ? k - 10 : 10 - k;
    case (d)
      0: return 24000;
      1: return 6000;
      2: return -2000;
      3: return 800;
      default: return 0;
    endcase
  endfunction
  function automatic int c2(int k);
    int d;
    d = (k > 31) ? k - 31 : 31 - k;
    return (32 - d) * 32;
  endfunction
  function automatic logic [21*16-1:0] pack1();
    logic [21*16-1:0] v;
    for (int k = 0; k < 21; k++) v[k*16 +: 16] = 16'(c1(k));
    return v;
  endfunction
  function automatic logic [63*16-1:0] pack2();
    logic [63*16-1:0] v;
    for (int k = 0; k < 63; k++) v[k*16 +: 16] = 16'(c2(k));
    return v;
  endfunction
  localparam logic [21*16-1:0] TB_C1 = pack1();
  localparam logic [63*16-1:0] TB_C2 = pack2();

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic out_valid;
  logic signed [15:0] out_data;
  always #2.5 clk = ~clk;

  ddc_decim_chain #(.COMP_COEFS(TB_C1), .SHAPE_COEFS(TB_C2)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  int n_checks = 0, n_fail = 0, n_out = 0, hold_bad = 0;
  longint last_out = 0;
  string cur_req = "R1 R2 R3";
  longint xs[$], cic_h[$], f1_h[$], exp_q[$];
  longint h[];
  bit done = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint rnd_sat(longint v, int s);
    longint t;
    t = (v + (longint'(1) <<< (s-1))) >>> s;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t;
  endfunction

  task automatic model_push(longint x);
    longint acc;
    int n;
    xs.push_back(x);
    if (xs.size() % 64 != 0) return;
    n = xs.size() - 1;
    acc = 0;
    for (int j = 0; j < h.size(); j++) if (n - j >= 0) acc += h[j] * xs[n-j];
    cic_h.push_back(rnd_sat(acc, 30));
    if (cic_h.size() % 2 != 0) return;
    n = cic_h.size() - 1;
    acc = 0;
    for (int k = 0; k < 21; k++) if (n - k >= 0) acc += longint'(c1(k)) * cic_h[n-k];
    f1_h.push_back(rnd_sat(acc, 15));
    if (f1_h.size() % 2 != 0) return;
    n = f1_h.size() - 1;
    acc = 0;
    for (int k = 0; k < 63; k++) if (n - k >= 0) acc += longint'(c2(k)) * f1_h[n-k];
    exp_q.push_back(rnd_sat(acc, 15));
  endtask

  // Output monitor: compares every pulse with the model, tracks holding.
  always @(negedge clk) begin
    if (rst) begin
      last_out = 0;
    end else if (out_valid) begin
      n_out++;
      if (exp_q.size() == 0) check(0, "R4", "unexpected output", out_data, 0);
      else check(out_data == exp_q.pop_front(), cur_req, "chain output", out_data, 0);
      last_out = out_data;
    end else if (out_data != last_out) begin
      hold_bad++;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    xs.delete(); cic_h.delete(); f1_h.delete(); exp_q.delete();
    n_out = 0;
    rst = 1'b0;
  endtask

  task automatic feed(longint x, bit v);
    @(negedge clk);
    in_valid = v;
    in_data = 16'(x);
    if (v) model_push(x);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (300) @(negedge clk);
    check(exp_q.size() == 0, "R4", "pending outputs", exp_q.size(), 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(out_valid == 1'b0, "R7", "out_valid after reset", out_valid, 0);
    check(out_data == 0, "R7", "out_data after reset", out_data, 0);
  endtask

  task automatic t_first_frame();
    do_reset();
    cur_req = "R1 R2 R3 R4";
    for (int i = 0; i < 255; i++) feed(i * 100 - 12000, 1'b1);
    drain();
    check(n_out == 0, "R4", "outputs before 256th input", n_out, 0);
    feed(3000, 1'b1);
    drain();
    check(n_out == 1, "R4", "outputs after 256th input", n_out, 1);
  endtask

  task automatic t_impulse();
    do_reset();
    cur_req = "R1 R2 R3";
    feed(20000, 1'b1);
    for (int i = 1; i < 256*16; i++) feed(0, 1'b1);
    drain();
    check(n_out == 16, "R1", "impulse output count", n_out, 16);
  endtask

  task automatic t_saturate();
    do_reset();
    cur_req = "R6 R2 R3";
    for (int i = 0; i < 256*40; i++) feed(32767, 1'b1);
    drain();
    check(last_out == 32767, "R6", "positive clamp", last_out, 32767);
    for (int i = 0; i < 256*40; i++) feed(-32768, 1'b1);
    drain();
    check(last_out == -32768, "R6", "negative clamp", last_out, -32768);
  endtask

  task automatic t_gaps();
    logic [15:0] lfsr = 16'hACE1;
    do_reset();
    cur_req = "R5 R1 R2 R3";
    for (int i = 0; i < 256*12*3; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 3 == 0) feed(longint'($signed(lfsr)) / 2, 1'b1);
      else feed(longint'($signed(~lfsr)), 1'b0);
    end
    drain();
    check(n_out == 12, "R5", "outputs with idle cycles", n_out, 12);
  endtask

  task automatic t_mid_reset();
    do_reset();
    cur_req = "R7 R1 R2 R3";
    for (int i = 0; i < 256*3 + 100; i++) feed(25000, 1'b1);
    do_reset();
    check(out_valid == 1'b0, "R7", "out_valid after mid-stream reset", out_valid, 0);
    check(out_data == 0, "R7", "out_data after mid-stream reset", out_data, 0);
    for (int i = 0; i < 256; i++) feed(-9000, 1'b1);
    drain();
    check(n_out == 1, "R7", "outputs in first frame after reset", n_out, 1);
  endtask

  initial begin
    longint tmp[];
    h = new[64];
    foreach (h[i]) h[i] = 1;
    for (int s = 1; s < 5; s++) begin
      tmp = new[h.size() + 63];
      foreach (tmp[i]) begin
        tmp[i] = 0;
        for (int j = 0; j < 64; j++) if (i - j >= 0 && i - j < h.size()) tmp[i] += h[i-j];
      end
      h = tmp;
    end
    t_reset_state();
    t_first_frame();
    t_impulse();
    t_saturate();
    t_gaps();
    t_mid_reset();
    check(hold_bad == 0, "R8", "out_data moved without out_valid", hold_bad, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule